// File: doc/BRIEF.md
# DMA Channel Request Qualifier and Arbiter

This block decides which DMA channel the transfer engine serves next. Each channel has five attribute bits: enable, mask, high priority, alternate-structure select and burst-only. Software changes each attribute through its own pair of write-one strobe vectors, one to set and one to clear. A bit of 1 acts on that channel alone, and a bit of 0 leaves it untouched. Peripherals drive one single-request line and one burst-request line per channel. The block filters these requests through the channel attributes and registers one winning channel index. Next to the index it gives a flag that tells a burst grant from a single grant.

The transfer engine returns two signals. A per-channel completion pulse clears that channel's enable bit, so the enable bit, read back, shows whether a transfer is still running. An acknowledge pulse marks the end of the current arbitration unit. The grant stays frozen until that acknowledge arrives, and only then is a new winner chosen. All attribute bits are visible as outputs. The alternate-select bit is held here for the engine and takes no part in arbitration.

Top module: `dma_req_qual`

## Requirements
- R1: After reset, all five attribute vectors read 0 and `gnt_valid` is 0.
- R2: A 1 in bit i of an attribute's set strobe makes that attribute bit 1 for channel i from the next cycle on. A 0 bit in a set or clear strobe leaves the stored bit unchanged.
- R3: A 1 in bit i of an attribute's clear strobe makes that bit 0 from the next cycle on. When set and clear hit the same bit in one cycle, the bit becomes 0.
- R4: A channel whose mask bit is 1 is never granted, whatever its request lines do.
- R5: A channel whose burst-only bit is 1 ignores its single-request line and can be granted only through its burst-request line. When burst-only is 0, either line makes the channel eligible.
- R6: `gnt_burst` is 1 when the winning channel had its burst-request line asserted at the arbitration edge, and 0 when only its single-request line was asserted.
- R7: Any eligible channel with priority bit 1 wins over every eligible channel with priority bit 0.
- R8: Among eligible channels of the same priority, the lowest channel number wins.
- R9: A channel whose enable bit is 0 is never granted.
- R10: A 1 in bit i of `xfer_done` clears enable bit i on the next cycle. This holds even when `en_set` bit i is 1 in the same cycle.
- R11: While `gnt_valid` is 1 and `unit_ack` is 0, `gnt_valid`, `gnt_idx` and `gnt_burst` hold their values. This holds even if the requests or attributes change.
- R12: At each clock edge where `gnt_valid` is 0 or `unit_ack` is 1, a new winner is chosen from the registered attributes and the current requests, and it appears on the next cycle. If no channel is eligible, `gnt_valid` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | NCH | Write-one-to-set strobes for enable |
| en_clr | input | NCH | Write-one-to-clear strobes for enable |
| pri_set | input | NCH | Write-one-to-set strobes for high priority |
| pri_clr | input | NCH | Write-one-to-clear strobes for high priority |
| alt_set | input | NCH | Write-one-to-set strobes for alternate select |
| alt_clr | input | NCH | Write-one-to-clear strobes for alternate select |
| bo_set | input | NCH | Write-one-to-set strobes for burst-only |
| bo_clr | input | NCH | Write-one-to-clear strobes for burst-only |
| msk_set | input | NCH | Write-one-to-set strobes for request mask |
| msk_clr | input | NCH | Write-one-to-clear strobes for request mask |
| sreq | input | NCH | Per-channel single-request lines |
| breq | input | NCH | Per-channel burst-request lines |
| xfer_done | input | NCH | Per-channel completion pulses from the engine |
| unit_ack | input | 1 | End of the current arbitration unit |
| en_q | output | NCH | Stored enable bits |
| pri_q | output | NCH | Stored priority bits |
| alt_q | output | NCH | Stored alternate-select bits |
| bo_q | output | NCH | Stored burst-only bits |
| msk_q | output | NCH | Stored mask bits |
| gnt_valid | output | 1 | A grant is held |
| gnt_idx | output | $clog2(NCH) | Granted channel number |
| gnt_burst | output | 1 | 1 for a burst grant, 0 for a single grant |

## Verification
Two kinds of event can land on the same enable bit in one cycle: a software write and a completion pulse. The bench raises `en_set` and `xfer_done` together on a running channel and expects the enable bit to read 0 afterwards. It also drives attribute writes in the very cycle that `unit_ack` forces a new choice. Because of the one-edge lag, the new winner must come from the attribute values that stood before the write. A scoreboard model, built from the requirements, computes both outcomes.

// File: rtl/dma_qual_pkg.sv
package dma_qual_pkg;
  // attribute slots in the packed write-strobe arrays
  localparam int ATTR_EN   = 0;
  localparam int ATTR_PRI  = 1;
  localparam int ATTR_ALT  = 2;
  localparam int ATTR_BO   = 3;
  localparam int ATTR_MSK  = 4;
  localparam int NUM_ATTR  = 5;
endpackage

// File: rtl/dma_attr_bank.sv
// One attribute vector with set/clear strobes plus a hardware clear source.
module dma_attr_bank #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic [NCH-1:0] hw_clr_i,
  output logic [NCH-1:0] q_o
);
  logic [NCH-1:0] q_r;
  logic [NCH-1:0] q_nxt;
  logic           upd;

  always_comb begin
    upd   = |(set_i | clr_i | hw_clr_i);
    // clear dominates set on the same bit
    q_nxt = (q_r | set_i) & ~(clr_i | hw_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (upd) begin
      q_r <= q_nxt;
    end
  end

  assign q_o = q_r;
endmodule

// File: rtl/dma_elig.sv
// Per-channel request qualification.
module dma_elig #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] msk_i,
  input  logic [NCH-1:0] bo_i,
  input  logic [NCH-1:0] sreq_i,
  input  logic [NCH-1:0] breq_i,
  output logic [NCH-1:0] elig_o,
  output logic [NCH-1:0] bq_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic live;
    logic qreq;
    always_comb begin
      live      = en_i[c] & ~msk_i[c];
      // burst-only channels drop single requests
      qreq      = breq_i[c] | (sreq_i[c] & ~bo_i[c]);
      elig_o[c] = live & qreq;
      bq_o[c]   = breq_i[c];
    end
  end
endmodule

// File: rtl/dma_pick.sv
// Two-class fixed-priority pick: high class first, lowest number within class.
module dma_pick #(
  parameter int NCH  = 8,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  elig_i,
  input  logic [NCH-1:0]  pri_i,
  output logic            found_o,
  output logic [IDXW-1:0] idx_o
);
  logic [NCH-1:0]  hi_v;
  logic [NCH-1:0]  lo_v;
  logic [IDXW-1:0] hi_idx;
  logic [IDXW-1:0] lo_idx;

  always_comb begin
    hi_v = elig_i & pri_i;
    lo_v = elig_i & ~pri_i;
  end

  // scan downward so the lowest set bit is the last one written
  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hi_v[i]) hi_idx = IDXW'(i);
      if (lo_v[i]) lo_idx = IDXW'(i);
    end
  end

  always_comb begin
    found_o = |elig_i;
    idx_o   = (|hi_v) ? hi_idx : lo_idx;
  end
endmodule

// File: rtl/dma_req_qual.sv
module dma_req_qual
  import dma_qual_pkg::*;
#(
  parameter int NCH  = 8,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  en_set,
  input  logic [NCH-1:0]  en_clr,
  input  logic [NCH-1:0]  pri_set,
  input  logic [NCH-1:0]  pri_clr,
  input  logic [NCH-1:0]  alt_set,
  input  logic [NCH-1:0]  alt_clr,
  input  logic [NCH-1:0]  bo_set,
  input  logic [NCH-1:0]  bo_clr,
  input  logic [NCH-1:0]  msk_set,
  input  logic [NCH-1:0]  msk_clr,
  input  logic [NCH-1:0]  sreq,
  input  logic [NCH-1:0]  breq,
  input  logic [NCH-1:0]  xfer_done,
  input  logic            unit_ack,
  output logic [NCH-1:0]  en_q,
  output logic [NCH-1:0]  pri_q,
  output logic [NCH-1:0]  alt_q,
  output logic [NCH-1:0]  bo_q,
  output logic [NCH-1:0]  msk_q,
  output logic            gnt_valid,
  output logic [IDXW-1:0] gnt_idx,
  output logic            gnt_burst
);
  logic [NUM_ATTR-1:0][NCH-1:0] set_a;
  logic [NUM_ATTR-1:0][NCH-1:0] clr_a;
  logic [NUM_ATTR-1:0][NCH-1:0] hw_a;
  logic [NUM_ATTR-1:0][NCH-1:0] q_a;

  always_comb begin
    set_a = '0;
    clr_a = '0;
    hw_a  = '0;
    set_a[ATTR_EN]  = en_set;   clr_a[ATTR_EN]  = en_clr;
    set_a[ATTR_PRI] = pri_set;  clr_a[ATTR_PRI] = pri_clr;
    set_a[ATTR_ALT] = alt_set;  clr_a[ATTR_ALT] = alt_clr;
    set_a[ATTR_BO]  = bo_set;   clr_a[ATTR_BO]  = bo_clr;
    set_a[ATTR_MSK] = msk_set;  clr_a[ATTR_MSK] = msk_clr;
    // engine completion retires the channel
    hw_a[ATTR_EN]   = xfer_done;
  end

  for (genvar a = 0; a < NUM_ATTR; a++) begin : g_attr
    dma_attr_bank #(.NCH(NCH)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_a[a]),
      .clr_i    (clr_a[a]),
      .hw_clr_i (hw_a[a]),
      .q_o      (q_a[a])
    );
  end

  assign en_q  = q_a[ATTR_EN];
  assign pri_q = q_a[ATTR_PRI];
  assign alt_q = q_a[ATTR_ALT];
  assign bo_q  = q_a[ATTR_BO];
  assign msk_q = q_a[ATTR_MSK];

  logic [NCH-1:0] elig_vec;
  logic [NCH-1:0] bq_vec;

  dma_elig #(.NCH(NCH)) u_elig (
    .en_i   (en_q),
    .msk_i  (msk_q),
    .bo_i   (bo_q),
    .sreq_i (sreq),
    .breq_i (breq),
    .elig_o (elig_vec),
    .bq_o   (bq_vec)
  );

  logic            win_found;
  logic [IDXW-1:0] win_idx;

  dma_pick #(.NCH(NCH)) u_pick (
    .elig_i  (elig_vec),
    .pri_i   (pri_q),
    .found_o (win_found),
    .idx_o   (win_idx)
  );

  // grant register: next-state and register processes
  logic            gv_r, gv_nxt;
  logic [IDXW-1:0] gi_r, gi_nxt;
  logic            gb_r, gb_nxt;
  logic            rearb;

  always_comb begin
    rearb  = ~gv_r | unit_ack;
    gv_nxt = win_found;
    gi_nxt = win_found ? win_idx : gi_r;
    gb_nxt = win_found & bq_vec[win_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_r <= 1'b0;
      gi_r <= '0;
      gb_r <= 1'b0;
    end else if (rearb) begin
      gv_r <= gv_nxt;
      gi_r <= gi_nxt;
      gb_r <= gb_nxt;
    end
  end

  assign gnt_valid = gv_r;
  assign gnt_idx   = gi_r;
  assign gnt_burst = gb_r;
endmodule

// File: rtl/dma_req_qual_chk.sv
module dma_req_qual_chk #(
  parameter int NCH  = 8,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  en_clr,
  input logic [NCH-1:0]  msk_clr,
  input logic [NCH-1:0]  xfer_done,
  input logic            unit_ack,
  input logic [NCH-1:0]  en_q,
  input logic [NCH-1:0]  msk_q,
  input logic [NCH-1:0]  pri_q,
  input logic [NCH-1:0]  bo_q,
  input logic [NCH-1:0]  elig_vec,
  input logic            gnt_valid,
  input logic [IDXW-1:0] gnt_idx,
  input logic            gnt_burst
);
  logic pick;
  assign pick = ~gnt_valid | unit_ack;

  // R3 / R10: cleared or completed channels read 0 afterwards
  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_clr | xfer_done) != '0) |=> ((en_q & $past(en_clr | xfer_done)) == '0));

  a_r3_mask_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_clr != '0) |=> ((msk_q & $past(msk_clr)) == '0));

  // R11: grant frozen until acknowledge
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !unit_ack) |=> (gnt_valid && $stable(gnt_idx) && $stable(gnt_burst)));

  // R12: a choice is made whenever one is due
  a_r12_take: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && (elig_vec != '0)) |=> gnt_valid);

  a_r12_none: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && (elig_vec == '0)) |=> !gnt_valid);

  // R9 / R4: winner was eligible at the pick edge
  a_r9_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && (elig_vec != '0)) |=> ((($past(elig_vec) >> gnt_idx) & 1) != 0));

  // R7: high class beats default class
  a_r7_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && ((elig_vec & pri_q) != '0)) |=> ((($past(pri_q) >> gnt_idx) & 1) != 0));

  // R5: single grant never goes to a burst-only channel
  a_r5_single_not_bo: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && (elig_vec != '0)) |=> (gnt_burst || ((($past(bo_q) >> gnt_idx) & 1) == 0)));
endmodule

bind dma_req_qual dma_req_qual_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_clr    (en_clr),
  .msk_clr   (msk_clr),
  .xfer_done (xfer_done),
  .unit_ack  (unit_ack),
  .en_q      (en_q),
  .msk_q     (msk_q),
  .pri_q     (pri_q),
  .bo_q      (bo_q),
  .elig_vec  (elig_vec),
  .gnt_valid (gnt_valid),
  .gnt_idx   (gnt_idx),
  .gnt_burst (gnt_burst)
);

// File: tb/tb_dma_req_qual.sv
`timescale 1ns/1ps
module tb_dma_req_qual;
  localparam int NCH  = 8;
  localparam int IDXW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NCH-1:0] en_set, en_clr, pri_set, pri_clr, alt_set, alt_clr;
  logic [NCH-1:0] bo_set, bo_clr, msk_set, msk_clr, sreq, breq, xfer_done;
  logic unit_ack;
  logic [NCH-1:0] en_q, pri_q, alt_q, bo_q, msk_q;
  logic gnt_valid, gnt_burst;
  logic [IDXW-1:0] gnt_idx;

  dma_req_qual #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n),
    .en_set(en_set), .en_clr(en_clr), .pri_set(pri_set), .pri_clr(pri_clr),
    .alt_set(alt_set), .alt_clr(alt_clr), .bo_set(bo_set), .bo_clr(bo_clr),
    .msk_set(msk_set), .msk_clr(msk_clr), .sreq(sreq), .breq(breq),
    .xfer_done(xfer_done), .unit_ack(unit_ack),
    .en_q(en_q), .pri_q(pri_q), .alt_q(alt_q), .bo_q(bo_q), .msk_q(msk_q),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_burst(gnt_burst)
  );

  typedef struct {
    string          tag;
    logic [NCH-1:0] en, pri, alt, bo, msk;
    logic           gv;
    int             gi;
    logic           gb;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // scoreboard model state
  logic [NCH-1:0] m_en = '0, m_pri = '0, m_alt = '0, m_bo = '0, m_msk = '0;
  logic m_gv = 1'b0;
  int   m_gi = 0;
  logic m_gb = 1'b0;

  task automatic clear_inputs();
    en_set = '0; en_clr = '0; pri_set = '0; pri_clr = '0;
    alt_set = '0; alt_clr = '0; bo_set = '0; bo_clr = '0;
    msk_set = '0; msk_clr = '0; xfer_done = '0; unit_ack = 1'b0;
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    e.tag = tag; e.en = m_en; e.pri = m_pri; e.alt = m_alt; e.bo = m_bo;
    e.msk = m_msk; e.gv = m_gv; e.gi = m_gi; e.gb = m_gb;
    exp_q.push_back(e);
  endtask

  // one clock: inputs already driven; model advances at the edge
  task automatic tick(input string tag);
    logic found;
    int   hi, lo;
    @(posedge clk);
    if (!m_gv || unit_ack) begin
      hi = -1; lo = -1;
      for (int i = 0; i < NCH; i++) begin
        if (m_en[i] && !m_msk[i] && (breq[i] || (sreq[i] && !m_bo[i]))) begin
          if (m_pri[i] && hi < 0) hi = i;
          if (!m_pri[i] && lo < 0) lo = i;
        end
      end
      found = (hi >= 0) || (lo >= 0);
      m_gv = found;
      if (found) begin
        m_gi = (hi >= 0) ? hi : lo;
        m_gb = breq[m_gi];
      end else begin
        m_gb = 1'b0;
      end
    end
    m_en  = (m_en  | en_set)  & ~(en_clr | xfer_done);
    m_pri = (m_pri | pri_set) & ~pri_clr;
    m_alt = (m_alt | alt_set) & ~alt_clr;
    m_bo  = (m_bo  | bo_set)  & ~bo_clr;
    m_msk = (m_msk | msk_set) & ~msk_clr;
    push_exp(tag);
    @(negedge clk);
    clear_inputs();
  endtask

  // monitor: compares at the falling edge, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        bit ok;
        e = exp_q.pop_front();
        ok = (en_q == e.en) && (pri_q == e.pri) && (alt_q == e.alt) &&
             (bo_q == e.bo) && (msk_q == e.msk) && (gnt_valid == e.gv);
        if (e.gv) ok = ok && (int'(gnt_idx) == e.gi) && (gnt_burst == e.gb);
        n_chk++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s: got en=%h pri=%h alt=%h bo=%h msk=%h v=%0d i=%0d b=%0d exp en=%h pri=%h alt=%h bo=%h msk=%h v=%0d i=%0d b=%0d",
                   e.tag, en_q, pri_q, alt_q, bo_q, msk_q, gnt_valid, gnt_idx, gnt_burst,
                   e.en, e.pri, e.alt, e.bo, e.msk, e.gv, e.gi, e.gb);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    sreq = '0; breq = '0;
    repeat (3) @(negedge clk);
    push_exp("R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    en_set = 8'hA5; tick("R2 enable set");
    alt_set = 8'h0F; tick("R2 alt set");
    tick("R2 zero strobes no effect");
    pri_set = 8'h30; pri_clr = 8'h10; tick("R3 clear wins on ch4");
    alt_clr = 8'h03; tick("R3 alt clear");

    sreq = 8'h05; tick("R8 lowest number wins");
    sreq = 8'h04; tick("R11 hold without ack");
    unit_ack = 1'b1; tick("R12 repick on ack");

    sreq = 8'h25; unit_ack = 1'b1; tick("R7 high priority ch5 wins");
    msk_set = 8'h20; tick("R11 hold while mask written");
    unit_ack = 1'b1; tick("R4 masked ch5 skipped");
    unit_ack = 1'b1; msk_set = 8'h01; tick("R12 pick uses pre-write attrs");
    unit_ack = 1'b1; tick("R4 masked ch0 skipped");
    msk_set = 8'h04; msk_clr = 8'h25; tick("R3 mask clear wins");

    en_clr = 8'h01; tick("R9 disable ch0");
    sreq = 8'h01; unit_ack = 1'b1; tick("R9 disabled ch0 not granted");

    bo_set = 8'h04; tick("R5 burst-only set ch2");
    sreq = 8'h04; unit_ack = 1'b1; tick("R5 single ignored on burst-only");
    sreq = 8'h04; breq = 8'h04; tick("R6 burst grant flag");
    breq = 8'h00; sreq = 8'h80; unit_ack = 1'b1; tick("R6 single grant flag");
    sreq = 8'h80; breq = 8'h80; unit_ack = 1'b1; tick("R6 both lines give burst");
    breq = 8'h00;

    xfer_done = 8'h80; tick("R10 done clears enable, grant held");
    en_set = 8'h80; xfer_done = 8'h80; tick("R10 done beats set");
    unit_ack = 1'b1; tick("R12 none eligible drops valid");
    sreq = 8'h00; en_set = 8'h02; pri_clr = 8'h20; tick("R2 re-enable ch1");
    sreq = 8'h22; bo_clr = 8'h04; tick("R8 same class lowest");
    tick("R11 idle hold");

    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule